// File: doc/BRIEF.md
# XY Route Decision Unit

This unit sits at one input port of a five-port mesh wormhole router. When a head flit arrives, it reads the destination coordinates and compares them with the router's own position. It then raises a single request toward the output-port arbiter. The ports are north, east, south, west and local. The choice follows dimension-ordered XY routing: the x offset is resolved first, then the y offset. When both offsets are zero the frame is delivered to the local port.

The head carries each 4-bit coordinate as two 1-of-4 digits. Each digit sits on its own 4-bit sub-channel. The request is held unchanged until two things have happened: the arbiter has granted it, and every one of the frame's sub-channels has reported its end-of-frame marker. Only then is the request withdrawn, and a one-cycle completion pulse is given. A head with a malformed digit is flagged as a routing error instead of being routed. So is a head that would turn traffic from the local port back to the local port. The frame is then drained, and the error flag is held until end-of-frame has been seen on all sub-channels.

Top module: `xy_route_unit`

## Requirements
- R1: The head word is 16 bits, made of four 4-bit one-hot digits. A digit whose bit k is set has the value k. Bits [3:0] hold the low digit of target x and [7:4] its high digit. Bits [11:8] hold the low digit of target y and [15:12] its high digit.
- R2: A target x above local x requests east, and a target x below local x requests west. This holds whatever the y values are.
- R3: When the target x equals local x, a target y above local y requests north and a target y below local y requests south.
- R4: When both coordinates are equal, the unit requests the local port. The request vector uses bit 0 for north, bit 1 for east, bit 2 for south, bit 3 for west and bit 4 for local.
- R5: If any head digit is not exactly one-hot, the unit raises route_err and raises no request.
- R6: While from_local is high, a head addressed to this router raises route_err instead of a local request.
- R7: The request appears on the cycle after the head is sampled. At most one request bit is ever high, and the request stays constant until it is released.
- R8: The request is released only after both a grant and an end-of-frame on all 16 sub-channels have been seen, in either order. On release, req goes to zero and frame_done pulses for one cycle.
- R9: route_err stays high until every sub-channel has delivered its end-of-frame. It then clears, and frame_done pulses.
- R10: A head_valid that arrives while a frame is being routed or drained has no effect on req or route_err.
- R11: After reset, req, route_err and frame_done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_x | input | 4 | This router's x coordinate |
| loc_y | input | 4 | This router's y coordinate |
| from_local | input | 1 | High when this unit serves the local input port |
| head_valid | input | 1 | Head flit present on head_dig |
| head_dig | input | 16 | Four 1-of-4 destination digits |
| eof_in | input | 16 | Per-sub-channel end-of-frame strobes |
| grant | input | 1 | Arbiter grant for the pending request |
| req | output | 5 | One-hot output-port request |
| route_err | output | 1 | Frame being drained as unroutable |
| frame_done | output | 1 | One-cycle pulse when a frame is released |

## Verification
The assertions check several properties on every cycle. They check that req is at most one-hot and never coexists with route_err. They check that a request or error stays put until it is released. They also check that any release is preceded by a full set of end-of-frame strobes and, for routed frames, by a grant. The bench alone shows that the port chosen is the right one for each coordinate relation. It also covers the decoding of digits and the rejection of malformed or local-to-local heads, and it shows that a head arriving mid-frame is ignored.

// File: rtl/xy_route_pkg.sv
package xy_route_pkg;
  localparam int N_PORT = 5;
  localparam int P_NORTH = 0;
  localparam int P_EAST  = 1;
  localparam int P_SOUTH = 2;
  localparam int P_WEST  = 3;
  localparam int P_LOCAL = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUTE = 2'd1,
    ST_DRAIN = 2'd2
  } rd_state_t;
endpackage

// File: rtl/xy_digit_dec.sv
module xy_digit_dec (
  input  logic [3:0] onehot,
  output logic [1:0] value,
  output logic       ok
);
  always_comb begin
    value = 2'd0;
    for (int k = 0; k < 4; k++)
      if (onehot[k]) value = 2'(k);
    ok = $onehot(onehot);
  end
endmodule

// File: rtl/xy_port_sel.sv
module xy_port_sel
  import xy_route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] tgt_x,
  input  logic [COORD_W-1:0] tgt_y,
  input  logic [COORD_W-1:0] own_x,
  input  logic [COORD_W-1:0] own_y,
  input  logic               from_local,
  output logic [N_PORT-1:0]  port,
  output logic               bad
);
  logic x_gt, x_lt, y_gt, y_lt;

  always_comb begin
    x_gt = tgt_x > own_x;
    x_lt = tgt_x < own_x;
    y_gt = tgt_y > own_y;
    y_lt = tgt_y < own_y;
    port = '0;
    if (x_gt)      port[P_EAST]  = 1'b1;
    else if (x_lt) port[P_WEST]  = 1'b1;
    else if (y_gt) port[P_NORTH] = 1'b1;
    else if (y_lt) port[P_SOUTH] = 1'b1;
    else           port[P_LOCAL] = 1'b1;
    bad = from_local && port[P_LOCAL];
  end
endmodule

// File: rtl/xy_eof_track.sv
module xy_eof_track #(
  parameter int N_SUB = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             clear,
  input  logic [N_SUB-1:0] eof_in,
  output logic             full
);
  logic [N_SUB-1:0] seen;

  assign full = &(seen | eof_in);

  always_ff @(posedge clk) begin
    if (rst || clear) seen <= '0;
    else if (enable)  seen <= seen | eof_in;
  end
endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
  import xy_route_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int N_SUB   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [COORD_W-1:0]         loc_x,
  input  logic [COORD_W-1:0]         loc_y,
  input  logic                       from_local,
  input  logic                       head_valid,
  input  logic [4*COORD_W-1:0]       head_dig,
  input  logic [N_SUB-1:0]           eof_in,
  input  logic                       grant,
  output logic [N_PORT-1:0]          req,
  output logic                       route_err,
  output logic                       frame_done
);
  localparam int DIG_PER = COORD_W / 2;
  localparam int N_DIG   = 2 * DIG_PER;

  logic [N_DIG-1:0]   dig_ok;
  logic [2*N_DIG-1:0] dig_val;
  logic [COORD_W-1:0] tgt_x, tgt_y;
  logic [N_PORT-1:0]  sel_port;
  logic               sel_bad;
  logic               eof_full;
  logic               release_now;
  logic               gnt_seen;
  rd_state_t          state;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    xy_digit_dec u_dec (
      .onehot (head_dig[4*g +: 4]),
      .value  (dig_val[2*g +: 2]),
      .ok     (dig_ok[g])
    );
  end

  assign tgt_x = dig_val[0 +: COORD_W];
  assign tgt_y = dig_val[COORD_W +: COORD_W];

  xy_port_sel #(.COORD_W(COORD_W)) u_sel (
    .tgt_x      (tgt_x),
    .tgt_y      (tgt_y),
    .own_x      (loc_x),
    .own_y      (loc_y),
    .from_local (from_local),
    .port       (sel_port),
    .bad        (sel_bad)
  );

  xy_eof_track #(.N_SUB(N_SUB)) u_eof (
    .clk    (clk),
    .rst    (rst),
    .enable (state != ST_IDLE),
    .clear  (release_now),
    .eof_in (eof_in),
    .full   (eof_full)
  );

  always_comb begin
    release_now = 1'b0;
    if (state == ST_ROUTE) release_now = eof_full && (gnt_seen || grant);
    if (state == ST_DRAIN) release_now = eof_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req        <= '0;
      route_err  <= 1'b0;
      frame_done <= 1'b0;
      gnt_seen   <= 1'b0;
    end else begin
      frame_done <= release_now;
      case (state)
        ST_IDLE: begin
          gnt_seen <= 1'b0;
          if (head_valid) begin
            if ((&dig_ok) && !sel_bad) begin
              req   <= sel_port;
              state <= ST_ROUTE;
            end else begin
              route_err <= 1'b1;
              state     <= ST_DRAIN;
            end
          end
        end
        ST_ROUTE: begin
          if (grant) gnt_seen <= 1'b1;
          if (release_now) begin
            req   <= '0;
            state <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (release_now) begin
            route_err <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xy_route_chk.sv
module xy_route_chk #(
  parameter int N_SUB = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       req,
  input logic             route_err,
  input logic             frame_done,
  input logic             grant,
  input logic [N_SUB-1:0] eof_in
);
  logic [N_SUB-1:0] acc_eof;
  logic             acc_gnt;
  logic             busy;

  assign busy = (|req) || route_err;

  always_ff @(posedge clk) begin
    if (rst || frame_done) begin
      acc_eof <= '0;
      acc_gnt <= 1'b0;
    end else if (busy) begin
      acc_eof <= acc_eof | eof_in;
      acc_gnt <= acc_gnt | grant;
    end
  end

  p_onehot_req_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req) && !((|req) && route_err));

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> (req == $past(req)) || (req == '0 && frame_done));

  p_err_held_r9: assert property (@(posedge clk) disable iff (rst)
    route_err |=> route_err || frame_done);

  p_all_eof_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> &acc_eof);

  p_grant_before_release_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !$past(route_err)) |-> acc_gnt);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

bind xy_route_unit xy_route_chk #(.N_SUB(N_SUB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .route_err  (route_err),
  .frame_done (frame_done),
  .grant      (grant),
  .eof_in     (eof_in)
);

// File: tb/sim_xy_route_unit.sv
module sim_xy_route_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: target x, target y, expected one-hot request (local 6,9)
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd9, 4'd9,  5'b00010},
    {4'd2, 4'd0,  5'b01000},
    {4'd6, 4'd12, 5'b00001},
    {4'd6, 4'd3,  5'b00100},
    {4'd6, 4'd9,  5'b10000},
    {4'd7, 4'd0,  5'b00010},
    {4'd5, 4'd15, 5'b01000},
    {4'd6, 4'd10, 5'b00001}
  };

  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  loc_x = 4'd6;
  logic [3:0]  loc_y = 4'd9;
  logic        from_local = 0;
  logic        head_valid = 0;
  logic [15:0] head_dig = '0;
  logic [15:0] eof_in = '0;
  logic        grant = 0;
  logic [4:0]  req;
  logic        route_err;
  logic        frame_done;
  int          checks = 0;
  int          fails = 0;
  bit          ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xy_route_unit u0 (
    .clk(clk), .rst(rst), .loc_x(loc_x), .loc_y(loc_y),
    .from_local(from_local), .head_valid(head_valid), .head_dig(head_dig),
    .eof_in(eof_in), .grant(grant), .req(req), .route_err(route_err),
    .frame_done(frame_done)
  );

  function automatic logic [15:0] enc(input logic [3:0] x, input logic [3:0] y);
    return {4'b1 << y[3:2], 4'b1 << y[1:0], 4'b1 << x[3:2], 4'b1 << x[1:0]};
  endfunction

  task automatic chk(input string r, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", r, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {req, route_err, frame_done};
  endfunction

  task automatic head(input logic [15:0] d);
    @(negedge clk); head_valid = 1; head_dig = d;
    @(negedge clk); head_valid = 0; head_dig = '0;
  endtask

  task automatic cyc_in(input logic [15:0] e, input logic g);
    @(negedge clk); eof_in = e; grant = g;
    @(negedge clk); eof_in = '0; grant = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", outs(), 7'b0);
    rst = 0;
    @(negedge clk);

    // table walk: R1 digit layout, R2/R3/R4 port choice, R7 hold, R8 release
    for (int i = 0; i < NVEC; i++) begin
      head(enc(VEC[i][12:9], VEC[i][8:5]));
      chk("R1 R2 R3 R4 routed request", outs(), {VEC[i][4:0], 2'b00});
      cyc_in(16'h00FF, 1'b1);
      chk("R7 request held after grant, partial eof", outs(), {VEC[i][4:0], 2'b00});
      cyc_in(16'hFF00, 1'b0);
      chk("R8 release after grant and all eof", outs(), 7'b0000001);
      @(negedge clk);
      chk("R8 done is one pulse", outs(), 7'b0);
    end

    // R8: all eof before grant keeps the request
    head(enc(4'd0, 4'd0));
    cyc_in(16'hFFFF, 1'b0);
    chk("R8 held without grant", outs(), 7'b0100000);
    cyc_in(16'h0000, 1'b1);
    chk("R8 release on late grant", outs(), 7'b0000001);

    // R5 zero digit, R9 drain
    head(16'h1240);
    chk("R5 zero digit error", outs(), 7'b0000010);
    cyc_in(16'h7FFF, 1'b1);
    chk("R9 error held until all eof", outs(), 7'b0000010);
    // R10 head while draining ignored
    head(enc(4'd9, 4'd9));
    chk("R10 head ignored while draining", outs(), 7'b0000010);
    cyc_in(16'h8000, 1'b0);
    chk("R9 error cleared with done", outs(), 7'b0000001);

    // R5 two-hot digit
    head(16'h1213);
    chk("R5 two-hot digit error", outs(), 7'b0000010);
    cyc_in(16'hFFFF, 1'b0);
    chk("R9 drain completes", outs(), 7'b0000001);

    // R6 local to local
    from_local = 1;
    head(enc(4'd6, 4'd9));
    chk("R6 local to local error", outs(), 7'b0000010);
    cyc_in(16'hFFFF, 1'b0);
    chk("R6 drain completes", outs(), 7'b0000001);
    head(enc(4'd6, 4'd2));
    chk("R6 local input may go south", outs(), 7'b0010000);
    // R10 head while routing ignored
    head(enc(4'd0, 4'd9));
    chk("R10 head ignored while routing", outs(), 7'b0010000);
    cyc_in(16'hFFFF, 1'b1);
    chk("R8 release", outs(), 7'b0000001);
    from_local = 0;

    // R11 reset in mid-frame
    head(enc(4'd1, 4'd1));
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R11 reset clears request", outs(), 7'b0);

    finish_run();
  end
endmodule